// File: doc/BRIEF.md
# Tiled Unsigned Multiplier with Low-Half Mode

This block multiplies two unsigned 16-bit operands by splitting each into an 8-bit low chunk and an 8-bit high chunk and feeding the four chunk pairings to four identical 8-by-8 tiles. Each tile builds eight AND-gated rows from its operands and adds them at their bit weights. The two cross sub-products are summed with their carry kept, placed 8 bits up, and added to the low-by-low tile and to the high-by-high tile, which sits 16 bits up.

A mode input picks between the full 32-bit product and a low-half mode. In low-half mode only bits 15:0 of the product are returned, and the upper 16 output bits read zero. The high-by-high tile has its inputs forced to zero in this mode, so it adds nothing and does not toggle.

An output register can be selected by parameter. When it is present, a result is captured on the clock edge where the input valid flag is high, and the output valid flag is raised from that edge on. An active-low synchronous reset clears both the product and the flag.

Top module: `tiled_mul`

## Requirements
- R1: Each 8-by-8 tile returns the exact unsigned 16-bit product of its two chunks. With both high operand bytes zero, product[15:0] equals lo(u) times lo(v).
- R2: When fullMode is 1, product equals the full unsigned 32-bit value u times v.
- R3: The sum of the two cross sub-products keeps its 17th bit, so no carry is lost. With u = v = 0xFFFF in full mode, the product is 0xFFFE0001.
- R4: When fullMode is 0, product[15:0] equals (u times v) modulo 65536.
- R5: When fullMode is 0, product[31:16] is zero for any operands.
- R6: When fullMode is 0, the high-by-high tile receives zero inputs and contributes nothing to the result.
- R7: With the output register on, a result is presented on the clock edge that follows a cycle with inValid = 1, and outValid is 1 from that same edge.
- R8: After a cycle with inValid = 0, outValid is 0 and product keeps its previous value.
- R9: When rstN is 0 at a clock edge, product and outValid both become zero.
- R10: A zero operand gives a zero product in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| fullMode | input | 1 | 1 = full 32-bit product, 0 = low 16 bits only |
| opU | input | 16 | First unsigned operand |
| opV | input | 16 | Second unsigned operand |
| product | output | 32 | Product; upper half is zero in low-half mode |
| outValid | output | 1 | The product register holds a fresh result |

## Verification
The hardest case to reach from the ports is the carry out of the cross-product sum. It only appears when both cross tiles give large values at the same time, so the stimulus uses operands whose high and low bytes are all near 0xFF. The gating of the high-by-high tile cannot be seen directly. To expose it, low-half mode is driven with large high bytes, and the bench checks that the upper output half stays zero and that the lower half still matches the modulo product.

// File: rtl/tmul_pkg.sv
package tmul_pkg;
  typedef struct packed {
    logic gateHiHi;   // force high-by-high tile inputs to zero
    logic maskUpper;  // clear upper half of the result
    logic capture;    // load output register
  } mulStrobes_t;
endpackage

// File: rtl/tmul_tile.sv
module tmul_tile #(
  parameter int CW = 8
) (
  input  logic [CW-1:0]   tileA,
  input  logic [CW-1:0]   tileB,
  output logic [2*CW-1:0] tileP
);
  localparam int PW = 2 * CW;

  logic [CW-1:0] rowBits [CW];

  genvar gi;
  generate
    for (gi = 0; gi < CW; gi++) begin : g_row
      assign rowBits[gi] = tileB & {CW{tileA[gi]}};
    end
  endgenerate

  always_comb begin
    tileP = '0;
    for (int i = 0; i < CW; i++) begin
      tileP = tileP + (PW'(rowBits[i]) << i);
    end
  end
endmodule

// File: rtl/tmul_ctrl.sv
module tmul_ctrl
  import tmul_pkg::*;
(
  input  logic        inValid,
  input  logic        fullMode,
  output mulStrobes_t strobes
);
  always_comb begin
    strobes.gateHiHi  = !fullMode;
    strobes.maskUpper = !fullMode;
    strobes.capture   = inValid;
  end
endmodule

// File: rtl/tmul_datapath.sv
module tmul_datapath
  import tmul_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobes_t     strobes,
  input  logic [2*CW-1:0] opU,
  input  logic [2*CW-1:0] opV,
  output logic [4*CW-1:0] result
);
  localparam int OW = 2 * CW;
  localparam int PW = 4 * CW;
  localparam int XW = OW + 1;

  logic [CW-1:0] uLo, uHi, vLo, vHi, hhA, hhB;
  logic [OW-1:0] prodLL, prodHL, prodLH, prodHH;
  logic [XW-1:0] crossSum;
  logic [PW-1:0] fullSum;
  logic [OW-1:0] lowSum;

  assign uLo = opU[CW-1:0];
  assign uHi = opU[OW-1:CW];
  assign vLo = opV[CW-1:0];
  assign vHi = opV[OW-1:CW];
  assign hhA = strobes.gateHiHi ? '0 : uHi;
  assign hhB = strobes.gateHiHi ? '0 : vHi;

  tmul_tile #(.CW(CW)) tileLL (.tileA(uLo), .tileB(vLo), .tileP(prodLL));
  tmul_tile #(.CW(CW)) tileHL (.tileA(uHi), .tileB(vLo), .tileP(prodHL));
  tmul_tile #(.CW(CW)) tileLH (.tileA(uLo), .tileB(vHi), .tileP(prodLH));
  tmul_tile #(.CW(CW)) tileHH (.tileA(hhA), .tileB(hhB), .tileP(prodHH));

  always_comb begin
    crossSum = XW'(prodHL) + XW'(prodLH);
    fullSum  = PW'(prodLL) + (PW'(crossSum) << CW) + (PW'(prodHH) << OW);
    lowSum   = prodLL + (OW'(crossSum[CW-1:0]) << CW);
    if (strobes.maskUpper) result = {{OW{1'b0}}, lowSum};
    else                   result = fullSum;
  end

  AST_HH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gateHiHi |-> (prodHH == '0)); // R6
  AST_LOW_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskUpper |-> (result[OW-1:0] == OW'(PW'(opU) * PW'(opV)))); // R4
  AST_TILE_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    prodLL == OW'(OW'(uLo) * OW'(vLo))); // R1
endmodule

// File: rtl/tiled_mul.sv
module tiled_mul
  import tmul_pkg::*;
#(
  parameter int CW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            fullMode,
  input  logic [2*CW-1:0] opU,
  input  logic [2*CW-1:0] opV,
  output logic [4*CW-1:0] product,
  output logic            outValid
);
  localparam int OW = 2 * CW;
  localparam int PW = 4 * CW;

  mulStrobes_t strobes;
  logic [PW-1:0] combResult;

  tmul_ctrl ctrl_i (
    .inValid (inValid),
    .fullMode(fullMode),
    .strobes (strobes)
  );

  tmul_datapath #(.CW(CW)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opU    (opU),
    .opV    (opV),
    .result (combResult)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [PW-1:0] prodQ;
      logic          validQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prodQ  <= '0;
          validQ <= 1'b0;
        end else begin
          validQ <= strobes.capture;
          if (strobes.capture) prodQ <= combResult;
        end
      end
      assign product  = prodQ;
      assign outValid = validQ;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid); // R7
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> (!outValid && $stable(product))); // R8
      AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && fullMode) |=> (product == PW'(PW'($past(opU)) * PW'($past(opV))))); // R2
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !fullMode) |=> (product[PW-1:OW] == '0)); // R5
    end else begin : g_comb
      assign product  = combResult;
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: tb/tiled_mul_tb.sv
module tiled_mul_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        fullMode = 1'b1;
  logic [15:0] opU = '0;
  logic [15:0] opV = '0;
  logic [31:0] product;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tiled_mul dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fullMode(fullMode),
    .opU(opU), .opV(opV), .product(product), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Present one operand pair for a single cycle, then read the registered result.
  task automatic issue(input logic [15:0] u, input logic [15:0] v, input logic full);
    @(negedge clk);
    opU = u; opV = v; fullMode = full; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] refMul(input logic [15:0] u, input logic [15:0] v, input logic full);
    logic [31:0] p;
    p = {16'h0, u} * {16'h0, v};
    if (!full) p = {16'h0, p[15:0]};
    return p;
  endfunction

  task automatic testReset();
    @(negedge clk);
    check("R9 reset product", product, 32'h0);
    check("R9 reset valid", {31'h0, outValid}, 32'h0);
  endtask

  task automatic testTile();
    issue(16'h00B7, 16'h00E5, 1'b1);
    check("R1 tile low bytes", product, 32'(16'hB7 * 16'hE5));
    check("R7 valid after input", {31'h0, outValid}, 32'h1);
  endtask

  task automatic testFull();
    logic [15:0] us [4] = '{16'h1234, 16'hABCD, 16'h8001, 16'h00FF};
    logic [15:0] vs [4] = '{16'h5678, 16'h0F0F, 16'hFFFE, 16'hFF00};
    for (int i = 0; i < 4; i++) begin
      issue(us[i], vs[i], 1'b1);
      check("R2 full product", product, refMul(us[i], vs[i], 1'b1));
    end
  endtask

  task automatic testCarry();
    issue(16'hFFFF, 16'hFFFF, 1'b1);
    check("R3 cross carry max", product, 32'hFFFE0001);
    issue(16'hFF80, 16'h80FF, 1'b1);
    check("R3 cross carry mixed", product, refMul(16'hFF80, 16'h80FF, 1'b1));
  endtask

  task automatic testLow();
    issue(16'hFFFF, 16'hFFFF, 1'b0);
    check("R4 low half max", {16'h0, product[15:0]}, 32'h0001);
    check("R5 upper zero max", {16'h0, product[31:16]}, 32'h0);
    issue(16'hC3A5, 16'h9E71, 1'b0);
    check("R4 low half", product, refMul(16'hC3A5, 16'h9E71, 1'b0));
    issue(16'hFF00, 16'hFF00, 1'b0);
    check("R6 hh tile has no effect", product, 32'h0);
  endtask

  task automatic testZero();
    issue(16'h0000, 16'hBEEF, 1'b1);
    check("R10 zero full", product, 32'h0);
    issue(16'hBEEF, 16'h0000, 1'b0);
    check("R10 zero low", product, 32'h0);
  endtask

  task automatic testIdle();
    logic [31:0] held;
    issue(16'h0102, 16'h0304, 1'b1);
    held = product;
    @(negedge clk);
    opU = 16'hFFFF; opV = 16'h7777; fullMode = 1'b0;
    @(negedge clk);
    check("R8 valid drops", {31'h0, outValid}, 32'h0);
    check("R8 product holds", product, held);
  endtask

  task automatic testResetMid();
    issue(16'h4321, 16'h1234, 1'b1);
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R9 reset clears product", product, 32'h0);
    check("R9 reset clears valid", {31'h0, outValid}, 32'h0);
    inValid = 1'b0; rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTile();
    testFull();
    testCarry();
    testLow();
    testZero();
    testIdle();
    testResetMid();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule